// File: doc/BRIEF.md
# Latch-Adder-Inverter Bank Mapper

This block sits on the CPU address and data bus of an 8-bit console cartridge and produces the upper ROM address lines. It has two PRG-ROM bank lines, which pick one of four 32 KiB program banks, and four CHR-ROM bank lines, which pick one of sixteen 8 KiB pattern banks. Software does not write the bank number directly. It first loads a 6-bit staging latch. A working register then either takes that value, with the low nibble optionally complemented, or counts its low nibble up by one. Finally, any write into the upper ROM space commits the working register to the bank outputs.

The register window compares only six address bits, so it appears many times across the low half of the address map. Reads from the window return the working register, with its top two bits optionally complemented. The working register's behaviour is held in a two-state machine with the states `WM_LOAD` and `WM_COUNT`. A write to the mode register with data bit 2 set takes the transition `to_count` (`WM_LOAD` → `WM_COUNT`). The same write with bit 2 clear takes the transition `to_load` (`WM_COUNT` → `WM_LOAD`). Any other access leaves the state where it is (`hold`).

A bus access is qualified by `cpu_strobe`. Writes, with `cpu_rw` low, take effect on the rising clock edge. Reads, with `cpu_rw` high, are answered combinationally in the same cycle.

Top module: `bank_latch_mapper`

## Requirements
- R1: A window access is one where (address AND 0xE103) equals 0x4100 + k, with k = 0..3 taken from A1..A0. A15, A14, A13 and A8 must read 0, 1, 0, 1. All other address bits are ignored, so addresses such as 0x5F7E and 0x41FD are mirrors of the window.
- R2: A write at window offset 2 loads the 6-bit staging latch from CPU data bits 7..2, with bit 7 going to latch bit 5.
- R3: A write at offset 1 sets the invert flag to data bit 2. A write at offset 3 moves the mode state machine to `WM_COUNT` when data bit 2 is 1, and to `WM_LOAD` when it is 0.
- R4: In `WM_LOAD`, a write at offset 0 copies the staging latch into the working register. Bits 3..0 are complemented when the invert flag is 1, and bits 5..4 are always copied unchanged.
- R5: In `WM_COUNT`, a write at offset 0 adds one to working-register bits 3..0, wrapping from 15 to 0 with no carry into bits 5..4. Those two bits stay unchanged.
- R6: A window read sets `cpu_data_oe` and drives working-register bit i onto data bit i+2. Data bits 7..6 are complemented when the invert flag is 1, and data bits 1..0 read 0. `cpu_data_oe` is low in every other cycle.
- R7: A write to any address from 0x8000 to 0xFFFF copies the working register into the output latch, whatever value is on the data bus.
- R8: `prg_bank[1]` is output-latch bit 5 and `prg_bank[0]` is output-latch bit 0. `chr_bank[3:0]` is output-latch bits 4..1. These outputs change only on a write to 0x8000-0xFFFF.
- R9: Reset clears the staging latch, working register, output latch and invert flag, and puts the state machine in `WM_LOAD`.
- R10: Reads, idle cycles, and writes outside both the window and 0x8000-0xFFFF change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_strobe | input | 1 | Bus access valid in this cycle |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | 16 | CPU address |
| cpu_data_in | input | 8 | CPU write data |
| cpu_data_out | output | 8 | Read data from the register window |
| cpu_data_oe | output | 1 | Read data is driven this cycle |
| prg_bank | output | 2 | PRG-ROM A16..A15 |
| chr_bank | output | 4 | CHR-ROM A16..A13 |

## Verification
The bench uses mirrored window addresses, and also near misses that differ only in A13 or A8. A decoder that compares too many or too few bits either misses those writes or takes stray ones. It checks that staging and loading leave the bank pins unchanged until a ROM-space write, so a design that drives the banks straight from the working register fails at once. It counts past 15 in count mode with bits 5..4 set, which catches a carry leaking into those bits. It also reads back with the invert flag on, which catches inversion applied to the wrong nibble on load or on read.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    localparam int unsigned ADDR_W   = 16;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned REG_W    = 6;
    localparam int unsigned CNT_W    = 4;
    localparam int unsigned DATA_LSB = DATA_W - REG_W;   // data bit carrying register bit 0
    localparam int unsigned FLAG_BIT = DATA_LSB;         // data bit carrying single-bit flags

    localparam logic [ADDR_W-1:0] WIN_MASK = 16'hE103;
    localparam logic [ADDR_W-1:0] WIN_BASE = 16'h4100;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_WORK_WR,
        ACC_INV_WR,
        ACC_STAGE_WR,
        ACC_MODE_WR,
        ACC_COMMIT,
        ACC_WIN_RD
    } acc_kind_e;

    typedef enum logic {
        WM_LOAD,
        WM_COUNT
    } work_mode_e;

endpackage

// File: rtl/mapper_addr_decode.sv
module mapper_addr_decode
    import mapper_pkg::*;
(
    input  logic              strobe,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind
);

    logic in_window;
    logic in_rom;

    assign in_window = ((addr & WIN_MASK) & ~ADDR_W'(3)) == WIN_BASE;
    assign in_rom    = addr[ADDR_W-1];

    always_comb begin
        kind = ACC_IDLE;
        if (strobe) begin
            if (rw) begin
                if (in_window) begin
                    kind = ACC_WIN_RD;
                end
            end else if (in_rom) begin
                kind = ACC_COMMIT;
            end else if (in_window) begin
                unique case (addr[1:0])
                    2'd0: kind = ACC_WORK_WR;
                    2'd1: kind = ACC_INV_WR;
                    2'd2: kind = ACC_STAGE_WR;
                    2'd3: kind = ACC_MODE_WR;
                    default: kind = ACC_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/mapper_work_unit.sv
module mapper_work_unit
    import mapper_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  acc_kind_e        kind,
    input  logic [REG_W-1:0] wr_field,
    input  logic             wr_flag,
    output logic [REG_W-1:0] work_q,
    output logic             inv_q
);

    work_mode_e       state_q, state_d;
    logic [REG_W-1:0] stage_q;
    logic [REG_W-1:0] work_d;
    logic [REG_W-1:0] load_val;
    logic [CNT_W-1:0] cnt_next;

    // State register for the working-register mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WM_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: to_count, to_load, hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WM_LOAD:  if (kind == ACC_MODE_WR && wr_flag)  state_d = WM_COUNT;
            WM_COUNT: if (kind == ACC_MODE_WR && !wr_flag) state_d = WM_LOAD;
            default:  state_d = WM_LOAD;
        endcase
    end

    // Load path: the counter nibble is optionally complemented, the upper bits pass through
    for (genvar i = 0; i < REG_W; i++) begin : g_load
        if (i < CNT_W) begin : g_inv
            assign load_val[i] = stage_q[i] ^ inv_q;
        end else begin : g_pass
            assign load_val[i] = stage_q[i];
        end
    end

    assign cnt_next = work_q[CNT_W-1:0] + CNT_W'(1);

    // Working-register update selected by the mode state
    always_comb begin
        work_d = work_q;
        if (kind == ACC_WORK_WR) begin
            unique case (state_q)
                WM_LOAD:  work_d = load_val;
                WM_COUNT: work_d = {work_q[REG_W-1:CNT_W], cnt_next};
                default:  work_d = work_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_q  <= '0;
            stage_q <= '0;
            inv_q   <= 1'b0;
        end else begin
            work_q <= work_d;
            if (kind == ACC_STAGE_WR) stage_q <= wr_field;
            if (kind == ACC_INV_WR)   inv_q   <= wr_flag;
        end
    end

endmodule

// File: rtl/mapper_read_format.sv
module mapper_read_format
    import mapper_pkg::*;
(
    input  acc_kind_e         kind,
    input  logic [REG_W-1:0]  work_q,
    input  logic              inv_q,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe
);

    localparam int unsigned HI_BITS = REG_W - CNT_W;

    logic [REG_W-1:0] view;

    assign rd_oe = (kind == ACC_WIN_RD);

    // The upper bits are complemented on the way out when the invert flag is set
    for (genvar i = 0; i < REG_W; i++) begin : g_view
        if (i >= REG_W - HI_BITS) begin : g_hi
            assign view[i] = work_q[i] ^ inv_q;
        end else begin : g_lo
            assign view[i] = work_q[i];
        end
    end

    assign rd_data = rd_oe ? {view, {DATA_LSB{1'b0}}} : '0;

endmodule

// File: rtl/mapper_bank_latch.sv
module mapper_bank_latch
    import mapper_pkg::*;
#(
    parameter int unsigned PRG_W   = 2,
    parameter int unsigned CHR_W   = 4,
    parameter int unsigned CHR_LSB = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  acc_kind_e        kind,
    input  logic [REG_W-1:0] work_q,
    output logic [PRG_W-1:0] prg_bank,
    output logic [CHR_W-1:0] chr_bank
);

    logic [REG_W-1:0] out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (kind == ACC_COMMIT) begin
            out_q <= work_q;
        end
    end

    // PRG lines come from the two outer register bits; CHR lines from the middle ones
    assign prg_bank = {out_q[REG_W-1], out_q[0]};
    assign chr_bank = out_q[CHR_LSB +: CHR_W];

endmodule

// File: rtl/bank_latch_mapper.sv
module bank_latch_mapper
    import mapper_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_strobe,
    input  logic              cpu_rw,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data_in,
    output logic [DATA_W-1:0] cpu_data_out,
    output logic              cpu_data_oe,
    output logic [1:0]        prg_bank,
    output logic [3:0]        chr_bank
);

    acc_kind_e        kind;
    logic [REG_W-1:0] work_q;
    logic             inv_q;
    logic             data_low_unused;

    assign data_low_unused = ^cpu_data_in[DATA_LSB-1:0];

    mapper_addr_decode u_dec (
        .strobe (cpu_strobe),
        .rw     (cpu_rw),
        .addr   (cpu_addr),
        .kind   (kind)
    );

    mapper_work_unit u_work (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .wr_field (cpu_data_in[DATA_W-1:DATA_LSB]),
        .wr_flag  (cpu_data_in[FLAG_BIT]),
        .work_q   (work_q),
        .inv_q    (inv_q)
    );

    mapper_read_format u_rd (
        .kind    (kind),
        .work_q  (work_q),
        .inv_q   (inv_q),
        .rd_data (cpu_data_out),
        .rd_oe   (cpu_data_oe)
    );

    mapper_bank_latch #(
        .PRG_W   (2),
        .CHR_W   (4),
        .CHR_LSB (1)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .work_q   (work_q),
        .prg_bank (prg_bank),
        .chr_bank (chr_bank)
    );

endmodule

// File: rtl/bank_latch_mapper_chk.sv
module bank_latch_mapper_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_strobe,
    input logic        cpu_rw,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_data_out,
    input logic        cpu_data_oe,
    input logic [1:0]  prg_bank,
    input logic [3:0]  chr_bank
);

    // R8
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_strobe && !cpu_rw && cpu_addr[15]) |=> ($stable(prg_bank) && $stable(chr_bank)));

    // R6
    oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_data_oe |-> (cpu_strobe && cpu_rw));

    // R6
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_data_oe |-> (cpu_data_out[1:0] == 2'b00));

    // R1
    oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_data_oe |-> (!cpu_addr[15] && cpu_addr[14] && !cpu_addr[13] && cpu_addr[8]));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (prg_bank == 2'b00 && chr_bank == 4'h0));

    // R10
    read_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_strobe && cpu_rw) |=> ($stable(prg_bank) && $stable(chr_bank)));

endmodule

bind bank_latch_mapper bank_latch_mapper_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_strobe   (cpu_strobe),
    .cpu_rw       (cpu_rw),
    .cpu_addr     (cpu_addr),
    .cpu_data_out (cpu_data_out),
    .cpu_data_oe  (cpu_data_oe),
    .prg_bank     (prg_bank),
    .chr_bank     (chr_bank)
);

// File: tb/bank_latch_mapper_tb.sv
module bank_latch_mapper_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_strobe = 1'b0;
    logic        cpu_rw = 1'b1;
    logic [15:0] cpu_addr = 16'h0;
    logic [7:0]  cpu_data_in = 8'h0;
    logic [7:0]  cpu_data_out;
    logic        cpu_data_oe;
    logic [1:0]  prg_bank;
    logic [3:0]  chr_bank;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // Behavioural reference state
    int m_stage = 0, m_work = 0, m_out = 0, m_inv = 0, m_mode = 0;

    always #5 clk = ~clk;

    bank_latch_mapper u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_strobe   (cpu_strobe),
        .cpu_rw       (cpu_rw),
        .cpu_addr     (cpu_addr),
        .cpu_data_in  (cpu_data_in),
        .cpu_data_out (cpu_data_out),
        .cpu_data_oe  (cpu_data_oe),
        .prg_bank     (prg_bank),
        .chr_bank     (chr_bank)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic bit in_win(input int a);
        return (a & 'hE100) == 'h4100;
    endfunction

    function automatic int exp_rd();
        int hi = ((m_work >> 4) & 3) ^ (m_inv != 0 ? 3 : 0);
        return ((hi << 4) | (m_work & 15)) << 2;
    endfunction

    function automatic void model_write(input int a, input int d);
        if (a >= 'h8000) begin
            m_out = m_work;
        end else if (in_win(a)) begin
            case (a & 3)
                0: if (m_mode == 0) m_work = (m_stage & 'h30) | ((m_stage & 15) ^ (m_inv != 0 ? 15 : 0));
                   else             m_work = (m_work & 'h30) | ((m_work + 1) & 15);
                1: m_inv = (d >> 2) & 1;
                2: m_stage = (d >> 2) & 63;
                default: m_mode = (d >> 2) & 1;
            endcase
        end
    endfunction

    // Bus cycle: drive at the falling edge, check combinational read data, update model after the rising edge
    task automatic bus(input bit rd, input int a, input int d);
        @(negedge clk);
        cpu_strobe  = 1'b1;
        cpu_rw      = rd;
        cpu_addr    = 16'(a);
        cpu_data_in = 8'(d);
        #2;
        if (rd) begin
            check("R1/R6 read oe", int'(cpu_data_oe), int'(in_win(a)));
            if (in_win(a)) check("R6 read data", int'(cpu_data_out), exp_rd());
        end else begin
            check("R6 oe low on write", int'(cpu_data_oe), 0);
        end
        @(posedge clk);
        #1;
        if (!rd) model_write(a, d);
        @(negedge clk);
        cpu_strobe = 1'b0;
        cpu_rw     = 1'b1;
    endtask

    // Compare bank pins with the model every cycle (R8)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R8 prg_bank", int'(prg_bank), (((m_out >> 5) & 1) << 1) | (m_out & 1));
            check("R8 chr_bank", int'(chr_bank), (m_out >> 1) & 15);
        end
    end

    initial begin
        #1500000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        #1;
        check("R9 prg after reset", int'(prg_bank), 0);
        check("R9 chr after reset", int'(chr_bank), 0);
        bus(1, 'h4100, 0);
        check("R9 read after reset", int'(cpu_data_out), 0);

        // R2 R4: load in WM_LOAD, no invert, via mirrors
        bus(0, 'h5F7E, 'hFC);          // stage = 0x3F
        bus(0, 'h41FC, 'h00);          // work  = 0x3F
        check("R8 banks before commit", int'({prg_bank, chr_bank}), 0);
        bus(1, 'h6100, 0);             // not a window (A13 set)
        check("R1 near miss no oe", int'(cpu_data_oe), 0);
        bus(1, 'h5D03, 0);
        check("R6 read 0x3F", int'(cpu_data_out), 'hFC);
        bus(0, 'h8000, 'h00);          // R7 commit, data ignored
        check("R7 prg after commit", int'(prg_bank), 3);
        check("R7 chr after commit", int'(chr_bank), 15);

        // R3 R4: invert flag, load complements low nibble only
        bus(0, 'h4101, 'h04);
        bus(0, 'h4100, 'h00);          // work = 0x30
        bus(1, 'h4102, 0);
        check("R6 read inverted hi", int'(cpu_data_out), 'h00);
        bus(0, 'hC000, 'hFF);
        check("R8 prg 0x30", int'(prg_bank), 2);
        check("R8 chr 0x30", int'(chr_bank), 8);

        // R10: stray writes outside window and ROM space
        bus(0, 'h4002, 'h00);          // A8 clear
        bus(0, 'h6102, 'h00);          // A13 set
        bus(0, 'h2100, 'h00);          // A14 clear
        bus(1, 'h4100, 0);
        check("R10 stray writes ignored", int'(cpu_data_out), 'h00);

        // R5: count mode wraps, bits 5..4 kept
        bus(0, 'h4103, 'h04);
        for (int i = 0; i < 17; i++) bus(0, 'h4100, 'hFF);
        bus(1, 'h4100, 0);
        check("R5 wrap read", int'(cpu_data_out), 'h04);
        bus(0, 'hFFFF, 'h55);
        check("R5 prg after wrap", int'(prg_bank), 3);
        check("R5 chr after wrap", int'(chr_bank), 8);

        // R3: back to load mode
        bus(0, 'h4103, 'hFB);
        bus(0, 'h4101, 'h00);
        bus(0, 'h4102, 'h54);          // stage = 0x15
        bus(0, 'h4100, 'h00);
        bus(1, 'h4100, 0);
        check("R3 load after mode clear", int'(cpu_data_out), 'h54);

        // Random traffic compared against the model
        for (int i = 0; i < 400; i++) begin
            int sel = $urandom_range(0, 5);
            int r = int'($urandom_range(0, 65535));
            int a;
            case (sel)
                0, 1, 2: a = (r & 'h1EFC) | 'h4100 | $urandom_range(0, 3);
                3:       a = r | 'h8000;
                default: a = r;
            endcase
            bus($urandom_range(0, 3) == 0, a, int'($urandom_range(0, 255)));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule